// File: doc/BRIEF.md
# Double-Buffered Video Descriptor Set Switcher

This block manages two banks of video output settings. Each bank holds a small descriptor memory and an image-size word that a pixel FIFO controller uses. One bank is live at a time. Software fills the idle bank and then writes a select bit in the mode word. The block moves the output to the selected bank only when the frame timing reports a frame boundary. A status output always shows the bank that is actually in use.

A background-force bit blanks the picture and leaves the timing running. While this bit is set, the block holds the pixel FIFO flushed. It also accepts a new buffer pointer and swaps banks at once instead of waiting for a boundary. When the bit is cleared, output resumes from whichever bank is live at that time. A warning output asks for background-force when the waiting image is too short to switch cleanly. Two further mode bits select the clock edge that launches pixel data and the polarity of that data.

Top module: `vidset_switch`

## Requirements
- R1: After reset, bank 0 is live, the select bit is 0, background-force is clear, and `fifo_flush`, `bg_select`, `swap_pending`, `ptr_load`, `wr_err` and `short_img` are all 0.
- R2: A write to the mode word stores `mode_wdata` bit 0 = select, bit 1 = background-force, bit 2 = launch edge, bit 3 = polarity, from the next clock. Outside background-force, `active_set` changes only at a clock where `frame_end` is high. At that clock it takes the select value held before that edge.
- R3: `swap_pending` is high exactly when the stored select differs from `active_set`. Writing the select back to the live bank before a boundary cancels the swap, and the next `frame_end` leaves `active_set` unchanged.
- R4: While background-force is stored, `bg_select` and `fifo_flush` are both 1, and `pix_out` shows the background level: all bits equal to the polarity bit.
- R5: While background-force is stored, a select value that differs from the live bank is taken into `active_set` one clock later, with no `frame_end` needed.
- R6: After background-force is cleared, `desc_rd_data` and `img_words` come from the bank then live, including values written during background-force.
- R7: A `ptr_wr` while background-force is stored raises `ptr_load` for one clock on the next clock, with `ptr_value` equal to the written pointer. At other times `ptr_wr` is ignored, and `ptr_load` stays 0.
- R8: `short_img` is 1 exactly when a swap is pending, background-force is clear, and the image-size word of the selected bank is below MIN_WORDS (24).
- R9: Bank writes (`set_ctl` = 1 writes the image-size word from the low bits of `set_wdata`, `set_ctl` = 0 writes descriptor word `set_addr`) are always accepted for the idle bank. A write to the live bank outside background-force is dropped, and it raises `wr_err` for one clock on the next clock.
- R10: `launch_fall` equals the stored launch-edge bit (1 = falling edge). Outside background-force, `pix_out` equals `pix_in` when polarity is 0 and its inverse when polarity is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | 4 | Mode word: select, background-force, launch edge, polarity |
| set_wr | input | 1 | Bank write strobe |
| set_bank | input | 1 | Bank addressed by the write |
| set_ctl | input | 1 | 1 = image-size word, 0 = descriptor word |
| set_addr | input | 3 | Descriptor word index |
| set_wdata | input | 16 | Bank write data |
| frame_end | input | 1 | Frame boundary pulse from timing |
| ptr_wr | input | 1 | Buffer pointer write strobe |
| ptr_wdata | input | 24 | Buffer pointer value |
| rd_addr | input | 3 | Descriptor read index into the live bank |
| pix_in | input | 8 | Pixel data from FIFO |
| active_set | output | 1 | Bank actually in use |
| swap_pending | output | 1 | Select differs from live bank |
| bg_select | output | 1 | Background frames forced |
| fifo_flush | output | 1 | Hold pixel FIFO flushed |
| ptr_load | output | 1 | Load buffer pointer pulse |
| ptr_value | output | 24 | Pointer to load |
| short_img | output | 1 | Pending image too short for a clean swap |
| wr_err | output | 1 | Write to live bank was dropped |
| launch_fall | output | 1 | Launch data on falling video clock edge |
| desc_rd_data | output | 16 | Descriptor word from the live bank |
| img_words | output | 12 | Image-size word of the live bank |
| pix_out | output | 8 | Pixel data after polarity and blanking |

## Verification
The collision that matters is a mode write that lands in the same clock as `frame_end`. The boundary must act on the select value stored before that edge, while the new value only takes effect afterwards. The vector table provokes this by rewriting the select in the boundary cycle, once when the write would have cancelled the swap. The judgement is that the live bank still flips, and that `swap_pending` then rises again until the next boundary. A second overlap is a write to the live bank in the same interval as background-force; it must be accepted without `wr_err` and must be readable after the force is cleared.

// File: rtl/vidset_pkg.sv
package vidset_pkg;
   localparam int MODE_BITS = 4;

   typedef struct packed {
      logic pol;
      logic ddt;
      logic bgf;
      logic sel;
   } mode_t;
endpackage

// File: rtl/vidset_mode_reg.sv
module vidset_mode_reg
   import vidset_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [MODE_BITS-1:0] wdata,
   output mode_t                mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= '0;
      else if (wr) mode <= mode_t'(wdata);
   end
endmodule

// File: rtl/vidset_bank.sv
module vidset_bank #(
   parameter int DESC_W     = 16,
   parameter int DESC_DEPTH = 8,
   parameter int SIZE_W     = 12,
   localparam int AW        = $clog2(DESC_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              ctl,
   input  logic [AW-1:0]     waddr,
   input  logic [DESC_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DESC_W-1:0] rdata,
   output logic [SIZE_W-1:0] size
);
   logic [DESC_W-1:0] words [DESC_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DESC_DEPTH; i++) words[i] <= '0;
         size <= '0;
      end else if (we) begin
         if (ctl) size <= wdata[SIZE_W-1:0];
         else     words[waddr] <= wdata;
      end
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/vidset_sel_ctrl.sv
module vidset_sel_ctrl #(
   parameter int PTR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             bgf,
   input  logic             frame_end,
   input  logic             set_wr,
   input  logic             set_bank,
   input  logic             ptr_wr,
   input  logic [PTR_W-1:0] ptr_wdata,
   output logic             active,
   output logic             pending,
   output logic             wr_accept,
   output logic             wr_err,
   output logic             ptr_load,
   output logic [PTR_W-1:0] ptr_value
);
   logic swap_now;

   assign pending   = (sel != active);
   assign swap_now  = pending && (bgf || frame_end);
   assign wr_accept = set_wr && ((set_bank != active) || bgf);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         wr_err    <= 1'b0;
         ptr_load  <= 1'b0;
         ptr_value <= '0;
      end else begin
         if (swap_now) active <= sel;
         wr_err   <= set_wr && !wr_accept;
         ptr_load <= ptr_wr && bgf;
         if (ptr_wr && bgf) ptr_value <= ptr_wdata;
      end
   end
endmodule

// File: rtl/vidset_switch.sv
module vidset_switch
   import vidset_pkg::*;
#(
   parameter int DESC_W     = 16,
   parameter int DESC_DEPTH = 8,
   parameter int SIZE_W     = 12,
   parameter int PTR_W      = 24,
   parameter int PIX_W      = 8,
   parameter int MIN_WORDS  = 24,
   localparam int AW        = $clog2(DESC_DEPTH),
   localparam int NBANK     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_wr,
   input  logic [MODE_BITS-1:0] mode_wdata,
   input  logic                 set_wr,
   input  logic                 set_bank,
   input  logic                 set_ctl,
   input  logic [AW-1:0]        set_addr,
   input  logic [DESC_W-1:0]    set_wdata,
   input  logic                 frame_end,
   input  logic                 ptr_wr,
   input  logic [PTR_W-1:0]     ptr_wdata,
   input  logic [AW-1:0]        rd_addr,
   input  logic [PIX_W-1:0]     pix_in,
   output logic                 active_set,
   output logic                 swap_pending,
   output logic                 bg_select,
   output logic                 fifo_flush,
   output logic                 ptr_load,
   output logic [PTR_W-1:0]     ptr_value,
   output logic                 short_img,
   output logic                 wr_err,
   output logic                 launch_fall,
   output logic [DESC_W-1:0]    desc_rd_data,
   output logic [SIZE_W-1:0]    img_words,
   output logic [PIX_W-1:0]     pix_out
);
   if (SIZE_W > DESC_W) begin : g_bad_size
      $error("SIZE_W must not exceed DESC_W");
   end
   if (DESC_DEPTH < 2) begin : g_bad_depth
      $error("DESC_DEPTH must be at least 2");
   end
   if (MIN_WORDS >= (1 << SIZE_W)) begin : g_bad_min
      $error("MIN_WORDS must fit in SIZE_W bits");
   end

   mode_t             mode;
   logic              wr_accept;
   logic [DESC_W-1:0] bank_rdata [NBANK];
   logic [SIZE_W-1:0] bank_size  [NBANK];

   vidset_mode_reg u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (mode_wr),
      .wdata (mode_wdata),
      .mode  (mode)
   );

   vidset_sel_ctrl #(.PTR_W(PTR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (mode.sel),
      .bgf       (mode.bgf),
      .frame_end (frame_end),
      .set_wr    (set_wr),
      .set_bank  (set_bank),
      .ptr_wr    (ptr_wr),
      .ptr_wdata (ptr_wdata),
      .active    (active_set),
      .pending   (swap_pending),
      .wr_accept (wr_accept),
      .wr_err    (wr_err),
      .ptr_load  (ptr_load),
      .ptr_value (ptr_value)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      vidset_bank #(
         .DESC_W    (DESC_W),
         .DESC_DEPTH(DESC_DEPTH),
         .SIZE_W    (SIZE_W)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_accept && (set_bank == 1'(b))),
         .ctl   (set_ctl),
         .waddr (set_addr),
         .wdata (set_wdata),
         .raddr (rd_addr),
         .rdata (bank_rdata[b]),
         .size  (bank_size[b])
      );
   end

   assign desc_rd_data = bank_rdata[active_set];
   assign img_words    = bank_size[active_set];
   assign bg_select    = mode.bgf;
   assign fifo_flush   = mode.bgf;
   assign launch_fall  = mode.ddt;
   assign short_img    = swap_pending && !mode.bgf &&
                         (bank_size[mode.sel] < SIZE_W'(MIN_WORDS));
   assign pix_out      = mode.bgf ? {PIX_W{mode.pol}} : (pix_in ^ {PIX_W{mode.pol}});
endmodule

// File: rtl/vidset_switch_chk.sv
module vidset_switch_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_end,
   input logic             set_wr,
   input logic             set_bank,
   input logic             active_set,
   input logic             swap_pending,
   input logic             bg_select,
   input logic             fifo_flush,
   input logic             ptr_load,
   input logic             short_img,
   input logic             wr_err,
   input logic [PIX_W-1:0] pix_out
);
   // R2
   hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bg_select && !frame_end) |=> $stable(active_set));

   // R3
   swap_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_set) |-> $past(swap_pending));

   // R4
   flush_in_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bg_select |-> fifo_flush);

   // R4
   bg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bg_select |-> ($countones(pix_out) == 0 || $countones(pix_out) == PIX_W));

   // R7
   ptr_only_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load |-> $past(bg_select));

   // R8
   short_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_img |-> (swap_pending && !bg_select));

   // R9
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(set_wr && (set_bank == active_set) && !bg_select));
endmodule

bind vidset_switch vidset_switch_chk #(.PIX_W(PIX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_end   (frame_end),
   .set_wr      (set_wr),
   .set_bank    (set_bank),
   .active_set  (active_set),
   .swap_pending(swap_pending),
   .bg_select   (bg_select),
   .fifo_flush  (fifo_flush),
   .ptr_load    (ptr_load),
   .short_img   (short_img),
   .wr_err      (wr_err),
   .pix_out     (pix_out)
);

// File: tb/vidset_switch_test.sv
module vidset_switch_test;
   localparam int PERIOD = 10;
   localparam int NVEC   = 15;

   // fields: mode_wr, sel, bgf, frame_end, exp_active, exp_pending, exp_flush
   typedef struct packed {
      logic mw; logic sel; logic bgf; logic fe;
      logic act; logic pend; logic fl;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{1,1,0,0, 0,1,0},  // R2 select written, no boundary
      '{0,0,0,0, 0,1,0},  // R2 still waiting
      '{0,0,0,1, 1,0,0},  // R2 boundary swaps
      '{1,0,0,0, 1,1,0},  // R3 pending back to 0
      '{1,1,0,0, 1,0,0},  // R3 cancel
      '{0,0,0,1, 1,0,0},  // R3 boundary after cancel: no change
      '{1,0,1,0, 1,1,1},  // R5 force on with select 0
      '{0,0,0,0, 0,0,1},  // R5 immediate swap
      '{1,1,1,0, 0,1,1},  // R5 select 1 under force
      '{0,0,0,0, 1,0,1},  // R5 immediate swap
      '{1,1,0,0, 1,0,0},  // R4 force cleared
      '{0,0,0,1, 1,0,0},  // R2 boundary, nothing pending
      '{1,0,0,0, 1,1,0},  // R3 pending
      '{1,1,0,1, 0,1,0},  // R2 write and boundary same clock
      '{0,0,0,1, 1,0,0}   // R2 next boundary settles
   };

   logic        clk = 0, rst_n = 0;
   logic        mode_wr = 0;
   logic [3:0]  mode_wdata = 0;
   logic        set_wr = 0, set_bank = 0, set_ctl = 0;
   logic [2:0]  set_addr = 0;
   logic [15:0] set_wdata = 0;
   logic        frame_end = 0, ptr_wr = 0;
   logic [23:0] ptr_wdata = 0;
   logic [2:0]  rd_addr = 0;
   logic [7:0]  pix_in = 0;
   logic        active_set, swap_pending, bg_select, fifo_flush, ptr_load;
   logic [23:0] ptr_value;
   logic        short_img, wr_err, launch_fall;
   logic [15:0] desc_rd_data;
   logic [11:0] img_words;
   logic [7:0]  pix_out;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   vidset_switch uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr();
      mode_wr = 0; set_wr = 0; frame_end = 0; ptr_wr = 0;
   endtask

   task automatic step();
      @(negedge clk);
      clr();
   endtask

   task automatic mode(input logic sel, input logic bgf, input logic ddt, input logic pol);
      mode_wr = 1; mode_wdata = {pol, ddt, bgf, sel};
      step();
   endtask

   task automatic bwrite(input logic bank, input logic ctl, input logic [2:0] a, input logic [15:0] d);
      set_wr = 1; set_bank = bank; set_ctl = ctl; set_addr = a; set_wdata = d;
      step();
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 active", active_set, 0);
      chk("R1 pending", swap_pending, 0);
      chk("R1 flush", fifo_flush, 0);
      chk("R1 bg", bg_select, 0);
      chk("R1 ptr_load", ptr_load, 0);
      chk("R1 wr_err", wr_err, 0);
      chk("R1 short", short_img, 0);

      for (int i = 0; i < NVEC; i++) begin
         mode_wr = VEC[i].mw;
         mode_wdata = {2'b00, VEC[i].bgf, VEC[i].sel};
         frame_end = VEC[i].fe;
         step();
         chk($sformatf("R2/R3/R5 vec%0d active", i), active_set, VEC[i].act);
         chk($sformatf("R3 vec%0d pending", i), swap_pending, VEC[i].pend);
         chk($sformatf("R4 vec%0d flush", i), fifo_flush, VEC[i].fl);
      end
      // now bank 1 live, select 1

      // R9 write to live bank dropped
      bwrite(1, 0, 3'd2, 16'hAAAA);
      chk("R9 wr_err pulse", wr_err, 1);
      rd_addr = 3'd2;
      #1;
      chk("R9 live bank unchanged", desc_rd_data, 16'h0000);
      step();
      chk("R9 wr_err one clock", wr_err, 0);

      // R9 writes to idle bank accepted
      bwrite(0, 0, 3'd2, 16'h1234);
      chk("R9 idle write no error", wr_err, 0);
      bwrite(0, 1, 3'd0, 16'd10);

      // R8 short image
      mode(0, 0, 0, 0);
      chk("R8 short with size 10", short_img, 1);
      bwrite(0, 1, 3'd0, 16'd24);
      chk("R8 size 24 not short", short_img, 0);
      bwrite(0, 1, 3'd0, 16'd23);
      chk("R8 size 23 short", short_img, 1);

      frame_end = 1;
      step();
      chk("R2 swap to bank 0", active_set, 0);
      chk("R6 read new bank", desc_rd_data, 16'h1234);
      chk("R6 size new bank", img_words, 12'd23);
      chk("R8 cleared after swap", short_img, 0);

      // R7 pointer ignored outside force
      ptr_wr = 1; ptr_wdata = 24'h654321;
      step();
      chk("R7 ignored load", ptr_load, 0);
      chk("R7 value kept", ptr_value, 24'h0);

      // force on
      mode(0, 1, 0, 0);
      pix_in = 8'h5A;
      #1;
      chk("R4 bg pix level pol0", pix_out, 8'h00);
      chk("R4 bg_select", bg_select, 1);
      ptr_wr = 1; ptr_wdata = 24'h123456;
      step();
      chk("R7 load pulse", ptr_load, 1);
      chk("R7 load value", ptr_value, 24'h123456);
      step();
      chk("R7 single pulse", ptr_load, 0);

      // write live bank under force
      bwrite(0, 0, 3'd3, 16'hBEEF);
      chk("R9 live write in force no error", wr_err, 0);

      mode(0, 0, 0, 0);
      rd_addr = 3'd3;
      #1;
      chk("R6 resume reads forced write", desc_rd_data, 16'hBEEF);
      chk("R6 flush released", fifo_flush, 0);
      chk("R10 pix pass pol0", pix_out, 8'h5A);

      // R10 edge and polarity
      mode(0, 0, 1, 1);
      #1;
      chk("R10 launch falling", launch_fall, 1);
      chk("R10 pix inverted", pix_out, 8'hA5);
      mode(0, 1, 1, 1);
      #1;
      chk("R4 bg pix level pol1", pix_out, 8'hFF);
      mode(0, 0, 0, 0);
      #1;
      chk("R10 launch rising", launch_fall, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule